// File: doc/BRIEF.md
# Two-Level DMA Channel Arbiter

This block decides which of seven DMA channels owns the shared bus for the next data item. Each channel presents a pending-request bit, an enable bit and a 2-bit software priority. A channel can compete only when it is enabled and has a request pending. Among the channels that can compete, the highest software priority wins. When several channels share that top level, the channel with the lowest index wins.

The arbiter decides only at item boundaries. While a grant is active it holds steady until the current owner signals that its item has finished. On the clock edge where item-done is high, a new decision is taken from the inputs present at that edge. While nothing is granted, the arbiter re-evaluates on every clock. The grant is a registered one-hot vector, together with the winning channel's index and a valid flag. All pins are plain control and status, so no valid/ready handshake or back-pressure applies at this edge.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, `grant_o` is all zeros, `grant_idx_o` is 0 and `grant_vld_o` is 0.
- R2: A channel is eligible only when both its `chan_req_i` bit and its `chan_en_i` bit are 1. A channel with only one of the two set is never granted.
- R3: Software priority is encoded per channel in `chan_prio_i[2*i+1:2*i]` as 2'b00 low, 2'b01 medium, 2'b10 high and 2'b11 ultra high. An eligible channel at a higher level always wins over one at a lower level, whatever the indices.
- R4: Among eligible channels at the same top level, the lowest channel index wins. Channel 0 ranks first and channel 6 ranks last.
- R5: While `grant_vld_o` is 1 and `item_done_i` is 0, the grant outputs keep their values. This holds even if the owner drops its request or enable, or if any priority or request changes.
- R6: A decision is taken at a rising edge where `grant_vld_o` is 0 or `item_done_i` is 1. It uses the inputs sampled at that edge, and the outputs show the result after that edge.
- R7: When a decision finds no eligible channel, `grant_o` becomes all zeros, `grant_idx_o` becomes 0 and `grant_vld_o` becomes 0.
- R8: `grant_o` is one-hot or zero. `grant_vld_o` equals the OR of `grant_o`, and when valid, `grant_o[grant_idx_o]` is 1.
- R9: While idle (`grant_vld_o` = 0), a request that becomes eligible is granted one edge later without any `item_done_i` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req_i | input | 7 | Pending request per channel |
| chan_en_i | input | 7 | Enable per channel |
| chan_prio_i | input | 14 | 2-bit software priority per channel, channel i at bits 2i+1:2i |
| item_done_i | input | 1 | Current owner finished its item; re-arbitrate at this edge |
| grant_o | output | 7 | One-hot grant |
| grant_idx_o | output | 3 | Index of the granted channel |
| grant_vld_o | output | 1 | A channel is granted |

## Verification
Every result of this block appears exactly one rising edge after the decision inputs are sampled. The outputs are registered, with no combinational path from inputs to outputs. The bench therefore drives inputs on the falling edge, lets one rising edge pass and compares on the following falling edge. A reference model advances its own held grant on that same edge. Hold behaviour is checked by changing requests and priorities with item-done low over several edges and confirming that the outputs stay put. The pulse of item-done then shows the new winner one edge later.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned PRIO_W  = 2;
  localparam int unsigned N_LEVEL = 1 << PRIO_W;

  typedef enum logic [PRIO_W-1:0] {
    LVL_LOW   = 2'b00,
    LVL_MED   = 2'b01,
    LVL_HIGH  = 2'b10,
    LVL_ULTRA = 2'b11
  } prio_lvl_e;
endpackage

// File: rtl/arb_level_scan.sv
module arb_level_scan
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_CH = 7
) (
  input  logic [N_CH-1:0]        elig,
  input  logic [N_CH*PRIO_W-1:0] prio_flat,
  output logic [PRIO_W-1:0]      top_level,
  output logic                   any_elig
);
  logic [N_LEVEL-1:0] level_hit;

  for (genvar l = 0; l < N_LEVEL; l++) begin : g_lvl
    logic [N_CH-1:0] at_lvl;
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign at_lvl[c] = elig[c] && (prio_flat[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
    assign level_hit[l] = |at_lvl;
  end

  always_comb begin
    top_level = '0;
    for (int l = 0; l < int'(N_LEVEL); l++) begin
      if (level_hit[l]) top_level = PRIO_W'(l);
    end
  end

  assign any_elig = |elig;
endmodule

// File: rtl/arb_level_mask.sv
module arb_level_mask
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_CH = 7
) (
  input  logic [N_CH-1:0]        elig,
  input  logic [N_CH*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]      top_level,
  output logic [N_CH-1:0]        cand
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign cand[c] = elig[c] && (prio_flat[c*PRIO_W +: PRIO_W] == top_level);
  end
endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int unsigned N_CH  = 7,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]  cand,
  output logic [N_CH-1:0]  pick_oh,
  output logic [IDX_W-1:0] pick_idx
);
  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    for (int c = int'(N_CH) - 1; c >= 0; c--) begin
      if (cand[c]) begin
        pick_oh  = '0;
        pick_oh[c] = 1'b1;
        pick_idx = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg #(
  parameter int unsigned N_CH  = 7,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decide,
  input  logic             win_vld,
  input  logic [N_CH-1:0]  win_oh,
  input  logic [IDX_W-1:0] win_idx,
  output logic [N_CH-1:0]  gnt_oh,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             gnt_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_oh  <= '0;
      gnt_idx <= '0;
      gnt_vld <= 1'b0;
    end else if (decide) begin
      gnt_vld <= win_vld;
      gnt_oh  <= win_vld ? win_oh  : '0;
      gnt_idx <= win_vld ? win_idx : '0;
    end
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_CH  = 7,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        chan_req_i,
  input  logic [N_CH-1:0]        chan_en_i,
  input  logic [N_CH*PRIO_W-1:0] chan_prio_i,
  input  logic                   item_done_i,
  output logic [N_CH-1:0]        grant_o,
  output logic [IDX_W-1:0]       grant_idx_o,
  output logic                   grant_vld_o
);
  logic [N_CH-1:0]   elig;
  logic [PRIO_W-1:0] top_level;
  logic              any_elig;
  logic [N_CH-1:0]   cand;
  logic [N_CH-1:0]   win_oh;
  logic [IDX_W-1:0]  win_idx;
  logic              decide;

  assign elig   = chan_req_i & chan_en_i;
  assign decide = !grant_vld_o || item_done_i;

  arb_level_scan #(.N_CH(N_CH)) u_scan (
    .elig(elig), .prio_flat(chan_prio_i),
    .top_level(top_level), .any_elig(any_elig)
  );

  arb_level_mask #(.N_CH(N_CH)) u_mask (
    .elig(elig), .prio_flat(chan_prio_i),
    .top_level(top_level), .cand(cand)
  );

  arb_fixed_pick #(.N_CH(N_CH)) u_pick (
    .cand(cand), .pick_oh(win_oh), .pick_idx(win_idx)
  );

  arb_grant_reg #(.N_CH(N_CH)) u_greg (
    .clk(clk), .rst_n(rst_n), .decide(decide),
    .win_vld(any_elig), .win_oh(win_oh), .win_idx(win_idx),
    .gnt_oh(grant_o), .gnt_idx(grant_idx_o), .gnt_vld(grant_vld_o)
  );
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_CH  = 7,
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_CH-1:0]        chan_req_i,
  input logic [N_CH-1:0]        chan_en_i,
  input logic [N_CH*PRIO_W-1:0] chan_prio_i,
  input logic                   item_done_i,
  input logic [N_CH-1:0]        grant_o,
  input logic [IDX_W-1:0]       grant_idx_o,
  input logic                   grant_vld_o
);
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R8
  grant_vld_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o == (|grant_o));

  // R8
  grant_idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld_o |-> grant_o[grant_idx_o]);

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && !item_done_i) |=> ($stable(grant_o) && $stable(grant_idx_o) && grant_vld_o));

  // R2
  grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld_o || item_done_i) |=> (!grant_vld_o || (|(grant_o & $past(chan_req_i & chan_en_i)))));

  // R7
  grant_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!grant_vld_o || item_done_i) && ((chan_req_i & chan_en_i) == '0)) |=> !grant_vld_o);
endmodule

bind dma_chan_arbiter dma_arb_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_req_i(chan_req_i), .chan_en_i(chan_en_i),
  .chan_prio_i(chan_prio_i), .item_done_i(item_done_i), .grant_o(grant_o),
  .grant_idx_o(grant_idx_o), .grant_vld_o(grant_vld_o)
);

// File: tb/sim_dma_chan_arbiter.sv
`timescale 1ns/1ps
module sim_dma_chan_arbiter;
  localparam int N = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] en = '0;
  logic [2*N-1:0] prio = '0;
  logic         done = 1'b0;
  logic [N-1:0] grant;
  logic [2:0]   gidx;
  logic         gvld;

  int tests = 0;
  int fails = 0;
  bit m_vld = 1'b0;
  int m_idx = 0;

  always #10 clk = ~clk;

  dma_chan_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .chan_req_i(req), .chan_en_i(en),
    .chan_prio_i(prio), .item_done_i(done), .grant_o(grant),
    .grant_idx_o(gidx), .grant_vld_o(gvld)
  );

  function automatic int ref_pick(logic [N-1:0] r, logic [N-1:0] e, logic [2*N-1:0] p);
    int best = -1;
    int bp = -1;
    for (int i = 0; i < N; i++) begin
      if (r[i] && e[i] && int'(p[2*i +: 2]) > bp) begin
        best = i;
        bp = int'(p[2*i +: 2]);
      end
    end
    return best;
  endfunction

  task automatic check(string tag);
    logic [N-1:0] eg;
    eg = '0;
    if (m_vld) eg[m_idx] = 1'b1;
    tests++;
    if (gvld !== m_vld || grant !== eg || gidx !== (m_vld ? 3'(m_idx) : 3'd0)) begin
      fails++;
      $display("FAIL %s: got vld=%0b grant=%b idx=%0d, expected vld=%0b grant=%b idx=%0d",
               tag, gvld, grant, gidx, m_vld, eg, m_vld ? m_idx : 0);
    end
  endtask

  // drive on falling edge, one rising edge, compare on next falling edge
  task automatic step(logic [N-1:0] r, logic [N-1:0] e, logic [2*N-1:0] p, logic d, string tag);
    int w;
    req = r; en = e; prio = p; done = d;
    if (!m_vld || d) begin
      w = ref_pick(r, e, p);
      m_vld = (w >= 0);
      m_idx = (w >= 0) ? w : 0;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [2*N-1:0] pr(int ch, logic [1:0] lv, logic [2*N-1:0] base);
    logic [2*N-1:0] t = base;
    t[2*ch +: 2] = lv;
    return t;
  endfunction

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R3: channel 6 ultra beats channel 0 low
    step(7'b100_0001, 7'h7F, pr(6, 2'b11, pr(0, 2'b00, '0)), 1'b0, "R3 high prio beats low index");
    // R4: equal level, lowest index
    step(7'b010_0100, 7'h7F, 14'h3FFF, 1'b1, "R4 same level lowest index");
    // R2: request without enable, enable without request
    step(7'b000_1010, 7'b011_1000, {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00}, 1'b1,
         "R2 only enabled and pending");
    // R5: hold while done low, despite changes
    step(7'b000_0001, 7'h7F, 14'h3FFF, 1'b0, "R5 hold after owner drops");
    step(7'b111_1111, 7'h7F, pr(0, 2'b11, '0), 1'b0, "R5 hold under priority change");
    step(7'b000_0000, 7'h00, '0, 1'b0, "R5 hold with nothing eligible");
    // R6: done pulse re-decides with present inputs
    step(7'b001_0001, 7'h7F, pr(4, 2'b10, '0), 1'b1, "R6 redecide on done");
    // R7: nothing eligible at decision
    step(7'b000_0000, 7'h7F, '0, 1'b1, "R7 no eligible clears grant");
    // R9: idle arbitration without done
    step(7'b000_0000, 7'h7F, '0, 1'b0, "R9 idle stays idle");
    step(7'b100_0000, 7'h7F, '0, 1'b0, "R9 idle grants without done");
    // R3 medium beats low; R4 tie at high between 3 and 5
    step(7'b000_0011, 7'h7F, pr(1, 2'b01, '0), 1'b1, "R3 medium beats low");
    step(7'b010_1000, 7'h7F, pr(5, 2'b10, pr(3, 2'b10, '0)), 1'b1, "R4 tie at high level");

    // random mix, R8 consistency and model compare
    for (int k = 0; k < 600; k++) begin
      logic [N-1:0] r, e;
      logic [2*N-1:0] p;
      r = N'($urandom);
      e = N'($urandom) | N'($urandom);
      p = (2*N)'($urandom);
      step(r, e, p, ($urandom % 3) == 0, "R8 random arbitration");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule